// File: doc/BRIEF.md
# Configurable Registered Address/Command Buffer

This block is a bank of registers for memory command and address lines. On each rising clock edge it captures a parallel input word and drives it from registered outputs. A static strap picks one of two widths. In the wide mode the block is a 25-bit one-to-one register: 22 general data bits plus the clock-enable, termination-enable and chip-select bits. In the duplicated mode it is a 14-bit register: 11 data bits plus the same three control bits, and every captured bit drives an A copy and a B copy. A second strap picks which slice of the input word feeds the duplicated register.

The general data outputs can be frozen. When the chip-select input and the companion hold-enable input are both high at a clock edge, the data outputs keep their value. The three control bits keep registering during a freeze. If the hold-enable input is tied low, the chip-select input is registered like any other bit.

An active-low reset clears every register and forces every output low at once, whatever the clock is doing. Its release is synchronized to the clock. Reset overrides the freeze.

Top module: `mab_regbuf`

## Requirements
- R1: While `rst_ni` is low, every output is 0. Asserting `rst_ni` clears the outputs at once, with no clock edge needed.
- R2: After `rst_ni` rises, the outputs stay 0 through the first two rising clock edges. Inputs are first captured at the third rising edge.
- R3: With `cfg_dup_i` = 0 (wide mode) and no freeze, `qa_o[i]` equals `d_i[i]` from the previous rising edge, for all 22 bits.
- R4: In wide mode, `qb_o`, `cke_b_o`, `odt_b_o` and `cs_b_o` are 0.
- R5: With `cfg_dup_i` = 1 and `cfg_alt_i` = 0, and no freeze, `qa_o[10:0]` and `qb_o[10:0]` both equal `d_i[10:0]` from the previous edge, and `qa_o[21:11]` is 0.
- R6: With `cfg_dup_i` = 1 and `cfg_alt_i` = 1, and no freeze, `qa_o[10:0]` and `qb_o[10:0]` both equal `d_i[21:11]` from the previous edge, and `qa_o[21:11]` is 0.
- R7: A freeze happens when `dcs_i` = 1 and `csr_i` = 1 at a rising edge. At that edge `qa_o` and `qb_o` keep their value.
- R8: `cke_a_o`, `odt_a_o` and `cs_a_o` register `cke_i`, `odt_i` and `dcs_i` at every active edge, frozen or not. In duplicated mode each B control copy equals its A copy.
- R9: With `csr_i` = 0, no freeze ever happens, whatever `dcs_i` does, and `cs_a_o` follows `dcs_i` one edge later.
- R10: Asserting `rst_ni` during a freeze still forces every output to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_dup_i | input | 1 | Width strap: 0 selects wide one-to-one, 1 selects duplicated |
| cfg_alt_i | input | 1 | Slice strap for duplicated mode: 0 selects the low slice, 1 selects the high slice |
| d_i | input | 22 | General data word |
| cke_i | input | 1 | Clock-enable bit |
| odt_i | input | 1 | Termination-enable bit |
| dcs_i | input | 1 | Chip-select bit, also a freeze condition |
| csr_i | input | 1 | Hold-enable, second freeze condition |
| qa_o | output | 22 | Registered data, A copy |
| qb_o | output | 11 | Registered data, B copy (duplicated mode only) |
| cke_a_o | output | 1 | Registered clock-enable, A copy |
| cke_b_o | output | 1 | Registered clock-enable, B copy |
| odt_a_o | output | 1 | Registered termination-enable, A copy |
| odt_b_o | output | 1 | Registered termination-enable, B copy |
| cs_a_o | output | 1 | Registered chip-select, A copy |
| cs_b_o | output | 1 | Registered chip-select, B copy |

## Verification
The bench builds the block with its defaults: a 25-bit wide mode and a 14-bit duplicated mode. With these values the 11-bit slice and the 22-bit word differ, so the low and high slices in R5 and R6 do not overlap, and zeroing the upper A-copy bits in duplicated mode can be observed. All three strap settings are entered under reset. Random data and random chip-select and hold-enable patterns drive the freeze in every mode. A reset asserted in the middle of a cycle during a freeze checks that reset wins.

// File: rtl/mab_pkg.sv
package mab_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE  = 2'd0,
    MODE_DUP_A = 2'd1,
    MODE_DUP_B = 2'd2
  } mode_e;

  typedef struct packed {
    logic cke;
    logic odt;
    logic cs;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic mode_e decode_mode(input logic dup, input logic alt);
    if (!dup) return MODE_WIDE;
    return alt ? MODE_DUP_B : MODE_DUP_A;
  endfunction
endpackage

// File: rtl/mab_rst_sync.sv
module mab_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign run_o = sync_q[STAGES-1];
endmodule

// File: rtl/mab_data_path.sv
module mab_data_path
  import mab_pkg::*;
#(
  parameter int unsigned DATA_W = 22,
  parameter int unsigned DUP_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              hold_i,
  input  mode_e             mode_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] qa_o,
  output logic [DUP_W-1:0]  qb_o
);
  localparam int unsigned HI_LSB = DATA_W - DUP_W;

  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] cap_q;
  mode_e             mode_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_sel
    if (i < DUP_W) begin : g_dup
      always_comb begin
        unique case (mode_i)
          MODE_DUP_A: nxt[i] = d_i[i];
          MODE_DUP_B: nxt[i] = d_i[HI_LSB+i];
          default:    nxt[i] = d_i[i];
        endcase
      end
    end else begin : g_wide
      // upper bits exist only in the one-to-one layout
      assign nxt[i] = (mode_i == MODE_WIDE) ? d_i[i] : 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      mode_q <= MODE_WIDE;
    end else if (run_i) begin
      mode_q <= mode_i;
      if (!hold_i) cap_q <= nxt;
    end
  end

  assign qa_o = cap_q;

  for (genvar j = 0; j < DUP_W; j++) begin : g_bcopy
    assign qb_o[j] = (mode_q != MODE_WIDE) & cap_q[j];
  end
endmodule

// File: rtl/mab_ctrl_reg.sv
module mab_ctrl_reg
  import mab_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  dup_i,
  input  ctrl_t ctrl_i,
  output ctrl_t a_o,
  output ctrl_t b_o
);
  ctrl_t ctrl_q;
  logic  dup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      dup_q  <= 1'b0;
    end else if (run_i) begin
      ctrl_q <= ctrl_i;
      dup_q  <= dup_i;
    end
  end

  assign a_o = ctrl_q;
  assign b_o = dup_q ? ctrl_q : '0;
endmodule

// File: rtl/mab_regbuf.sv
module mab_regbuf
  import mab_pkg::*;
#(
  parameter int unsigned WIDE_W     = 25,
  parameter int unsigned NARROW_W   = 14,
  parameter int unsigned SYNC_DEPTH = 2,
  localparam int unsigned DATA_W    = WIDE_W - CTRL_W,
  localparam int unsigned DUP_W     = NARROW_W - CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_dup_i,
  input  logic              cfg_alt_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic              cke_i,
  input  logic              odt_i,
  input  logic              dcs_i,
  input  logic              csr_i,
  output logic [DATA_W-1:0] qa_o,
  output logic [DUP_W-1:0]  qb_o,
  output logic              cke_a_o,
  output logic              cke_b_o,
  output logic              odt_a_o,
  output logic              odt_b_o,
  output logic              cs_a_o,
  output logic              cs_b_o
);
  logic  run_q;
  logic  hold;
  mode_e mode;
  ctrl_t ctrl_in, ctrl_a, ctrl_b;

  assign hold    = dcs_i & csr_i;
  assign mode    = decode_mode(cfg_dup_i, cfg_alt_i);
  assign ctrl_in = '{cke: cke_i, odt: odt_i, cs: dcs_i};

  mab_rst_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_o  (run_q)
  );

  mab_data_path #(.DATA_W(DATA_W), .DUP_W(DUP_W)) u_data (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .hold_i (hold),
    .mode_i (mode),
    .d_i    (d_i),
    .qa_o   (qa_o),
    .qb_o   (qb_o)
  );

  mab_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .dup_i  (cfg_dup_i),
    .ctrl_i (ctrl_in),
    .a_o    (ctrl_a),
    .b_o    (ctrl_b)
  );

  assign cke_a_o = ctrl_a.cke;
  assign odt_a_o = ctrl_a.odt;
  assign cs_a_o  = ctrl_a.cs;
  assign cke_b_o = ctrl_b.cke;
  assign odt_b_o = ctrl_b.odt;
  assign cs_b_o  = ctrl_b.cs;
endmodule

// File: rtl/mab_regbuf_chk.sv
module mab_regbuf_chk #(
  parameter int unsigned DATA_W = 22,
  parameter int unsigned DUP_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              cfg_dup_i,
  input logic              cfg_alt_i,
  input logic [DATA_W-1:0] d_i,
  input logic              cke_i,
  input logic              odt_i,
  input logic              dcs_i,
  input logic              csr_i,
  input logic [DATA_W-1:0] qa_o,
  input logic [DUP_W-1:0]  qb_o,
  input logic              cke_a_o,
  input logic              cke_b_o,
  input logic              odt_a_o,
  input logic              odt_b_o,
  input logic              cs_a_o,
  input logic              cs_b_o
);
  localparam int unsigned HI_LSB = DATA_W - DUP_W;

  logic frz;
  assign frz = dcs_i & csr_i;

  // R1 R10
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      r1_reset_low_chk: assert (qa_o == '0 && qb_o == '0 && !cke_a_o && !cke_b_o
                                && !odt_a_o && !odt_b_o && !cs_a_o && !cs_b_o);
    end
  end

  // R2
  r2_quiet_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (qa_o == '0 && !cke_a_o && !cs_a_o && !odt_a_o));

  // R3
  r3_wide_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cfg_dup_i && !frz) |=> qa_o == $past(d_i));

  // R4
  r4_wide_b_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_dup_i |=> (qb_o == '0 && !cke_b_o && !odt_b_o && !cs_b_o));

  // R5
  r5_dup_low_slice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cfg_dup_i && !cfg_alt_i && !frz) |=> qb_o == $past(d_i[DUP_W-1:0]));

  // R6
  r6_dup_high_slice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cfg_dup_i && cfg_alt_i && !frz) |=> qb_o == $past(d_i[HI_LSB +: DUP_W]));

  // R7
  r7_freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz |=> ($stable(qa_o) && $stable(qb_o)));

  // R8
  r8_ctrl_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (cke_a_o == $past(cke_i) && odt_a_o == $past(odt_i)));

  // R8
  r8_dup_copies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_dup_i |=> (cke_b_o == cke_a_o && odt_b_o == odt_a_o && cs_b_o == cs_a_o));

  // R9
  r9_cs_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !csr_i) |=> cs_a_o == $past(dcs_i));
endmodule

bind mab_regbuf mab_regbuf_chk #(.DATA_W(DATA_W), .DUP_W(DUP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_q),
  .cfg_dup_i (cfg_dup_i),
  .cfg_alt_i (cfg_alt_i),
  .d_i       (d_i),
  .cke_i     (cke_i),
  .odt_i     (odt_i),
  .dcs_i     (dcs_i),
  .csr_i     (csr_i),
  .qa_o      (qa_o),
  .qb_o      (qb_o),
  .cke_a_o   (cke_a_o),
  .cke_b_o   (cke_b_o),
  .odt_a_o   (odt_a_o),
  .odt_b_o   (odt_b_o),
  .cs_a_o    (cs_a_o),
  .cs_b_o    (cs_b_o)
);

// File: tb/mab_regbuf_tb_top.sv
`timescale 1ns/1ps
module mab_regbuf_tb_top;
  localparam int unsigned DATA_W = 22;
  localparam int unsigned DUP_W  = 11;
  localparam int unsigned OUT_W  = DATA_W + DUP_W + 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              c_dup = 1'b0, c_alt = 1'b0;
  logic [DATA_W-1:0] d = '0;
  logic              cke = 1'b0, odt = 1'b0, dcs = 1'b0, csr = 1'b0;
  logic [DATA_W-1:0] qa;
  logic [DUP_W-1:0]  qb;
  logic              cke_a, cke_b, odt_a, odt_b, cs_a, cs_b;

  int n_chk = 0;
  int n_err = 0;
  int sync_cnt = 0;

  logic [DATA_W-1:0] e_qa = '0;
  logic [DUP_W-1:0]  e_qb = '0;
  logic [2:0]        e_ca = '0, e_cb = '0;

  always #2 clk = ~clk;

  mab_regbuf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_dup_i(c_dup), .cfg_alt_i(c_alt),
    .d_i(d), .cke_i(cke), .odt_i(odt), .dcs_i(dcs), .csr_i(csr),
    .qa_o(qa), .qb_o(qb), .cke_a_o(cke_a), .cke_b_o(cke_b),
    .odt_a_o(odt_a), .odt_b_o(odt_b), .cs_a_o(cs_a), .cs_b_o(cs_b)
  );

  function automatic logic [DUP_W-1:0] slice(input logic alt, input logic [DATA_W-1:0] w);
    return alt ? w[DATA_W-1 -: DUP_W] : w[DUP_W-1:0];
  endfunction

  function automatic logic [OUT_W-1:0] pack_out(
    input logic [DATA_W-1:0] a, input logic [DUP_W-1:0] b,
    input logic [2:0] ca, input logic [2:0] cb);
    return {a, b, ca[2], cb[2], ca[1], cb[1], ca[0], cb[0]};
  endfunction

  task automatic check(input string req);
    logic [OUT_W-1:0] act, exp;
    act = {qa, qb, cke_a, cke_b, odt_a, odt_b, cs_a, cs_b};
    exp = pack_out(e_qa, e_qb, e_ca, e_cb);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst_n) begin
      if (sync_cnt >= 2) begin
        e_ca = {cke, odt, dcs};
        e_cb = c_dup ? {cke, odt, dcs} : 3'b000;
        if (!(dcs && csr)) begin
          if (!c_dup) begin
            e_qa = d;
            e_qb = '0;
          end else begin
            e_qa = {{(DATA_W-DUP_W){1'b0}}, slice(c_alt, d)};
            e_qb = slice(c_alt, d);
          end
        end
      end
      if (sync_cnt < 2) sync_cnt++;
    end
  endtask

  // drive: 0 = hold-enable low, 1 = forced freeze, 2 = random pair
  task automatic randomize_in(input int kind);
    d   = DATA_W'($urandom());
    cke = 1'($urandom());
    odt = 1'($urandom());
    dcs = 1'($urandom());
    case (kind)
      0: csr = 1'b0;
      1: begin dcs = 1'b1; csr = 1'b1; end
      default: csr = 1'($urandom());
    endcase
  endtask

  task automatic step(input string req, input int kind);
    @(posedge clk);
    model_edge();
    #1;
    check(req);
    randomize_in(kind);
  endtask

  task automatic enter_reset(input logic dup, input logic alt);
    #1;
    rst_n = 1'b0;
    sync_cnt = 0;
    e_qa = '0; e_qb = '0; e_ca = '0; e_cb = '0;
    #0.5;
    check("R1");
    c_dup = dup;
    c_alt = alt;
    @(posedge clk);
    #1;
    check("R1");
    randomize_in(2);
    rst_n = 1'b1;
    step("R2", 0);
    step("R2", 0);
  endtask

  initial begin : watchdog
    #400000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    randomize_in(2);
    #1;
    check("R1");
    @(posedge clk);
    #1;
    check("R1");

    // wide mode
    enter_reset(1'b0, 1'b0);
    for (int i = 0; i < 40; i++) step("R3,R4,R9", 0);
    d = '1; csr = 1'b0; dcs = 1'b1;
    step("R3", 0);
    step("R3,R9", 1);
    for (int i = 0; i < 6; i++) step("R7,R8", 1);
    for (int i = 0; i < 80; i++) step("R3,R4,R7,R8", 2);

    // reset wins during a freeze
    d = '1; dcs = 1'b1; csr = 1'b1; cke = 1'b1; odt = 1'b1;
    step("R7", 1);
    step("R7", 1);
    enter_reset(1'b1, 1'b0);
    check("R10");

    // duplicated, low slice
    for (int i = 0; i < 40; i++) step("R5,R8", 0);
    for (int i = 0; i < 60; i++) step("R5,R7,R8", 2);

    // duplicated, high slice
    enter_reset(1'b1, 1'b1);
    d = {{(DATA_W-DUP_W){1'b1}}, {DUP_W{1'b0}}};
    csr = 1'b0;
    step("R6", 0);
    for (int i = 0; i < 40; i++) step("R6,R8", 0);
    for (int i = 0; i < 60; i++) step("R6,R7,R8,R9", 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule